// File: doc/BRIEF.md
# Armed-at-Reset Watchdog with Keyed Stop

This block is a watchdog counter for a system controller. It is armed after any reset, whether power-on or soft. It counts up on every enabled counter tick. If software neither reloads it nor stops it before the count passes its all-ones value, the block raises a one-cycle system reset request. The counter then restarts from a programmable reload value.

Software can stop the counter in only one way: by writing two fixed key words, in the right order, to a key register. The same two-step scheme with a different pair of words starts the counter again. Each key write is posted and does not act at once. A pending flag in a status register stays up until the key has reached the counter logic, and further key writes are dropped until that happens. A self-clearing soft-reset bit returns all state to its reset values and arms the counter again. A reset-done status bit tells software when the block can be used.

The register bus is synchronous. A write takes effect at the clock edge where its write enable is sampled high. Read data is a combinational function of the address and of the current register state.

Top module: `wdog_keyseq`

## Requirements
- R1: After the reset input is released, the counter (0x28) and the reload value (0x2C) both read LOAD_INIT and the counter is running. The pending bit (bit 4 of 0x34) reads 0, reset-done (bit 0 of 0x14) reads 1, the soft-reset bit (bit 0 of 0x10) reads 0, and resetReq is low.
- R2: While running, the counter goes up by one on each clock edge where tick is high. With tick low and no register write, it holds its value.
- R3: A tick while the counter is all ones loads the counter from the reload register. resetReq is then high for exactly the cycle that follows that edge.
- R4: The reload register at 0x2C can be read and written. A write of any value to 0x30 copies the reload value into the counter, and a reload write alone leaves the counter unchanged.
- R5: A key write of 0x0000AAAA followed by a key write of 0x00005555, both to 0x48, stops the counter. The counter then ignores ticks.
- R6: After 0x0000AAAA, any key value other than 0x00005555 returns the sequence to its first step and leaves the run state unchanged. Writing 0x5555 before 0xAAAA has no effect.
- R7: A key write of 0x0000BBBB followed by a key write of 0x00004444 starts a stopped counter.
- R8: A key write accepted while bit 4 of 0x34 is 0 sets that bit. The bit clears on the POST_TICKS-th following tick, and the key takes effect at that same edge. A key write made while the bit is 1 is dropped and does not restart the delay.
- R9: Writing 1 to bit 0 of 0x10 starts a soft reset that lasts SRST_CYCLES cycles. During it, that bit reads 1, reset-done reads 0 and bus writes are ignored. When it ends, reset-done reads 1 and all state holds its R1 values, with the counter running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable |
| busRdata | output | 32 | Read data for busAddr |
| resetReq | output | 1 | One-cycle system reset request on overflow |

## Verification
The bench builds the block with a 10-bit counter and a reload reset value of 0x3C0, so the first timeout comes after only 64 ticks. It uses a 4-tick posting delay and a 6-cycle soft reset. With that width the bench can sweep every reload value from 0x3EB to 0x3FF, plus 0 and 0x200, through a full count to overflow, and predict the exact tick of every reset request. The short posting and soft-reset windows let each key ordering, each dropped write and the whole soft-reset sequence be checked cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SYSCFG   = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_SYSSTAT  = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_COUNT    = 8'h28;
  localparam logic [ADDR_W-1:0] ADR_LOAD     = 8'h2C;
  localparam logic [ADDR_W-1:0] ADR_KICK     = 8'h30;
  localparam logic [ADDR_W-1:0] ADR_POSTSTAT = 8'h34;
  localparam logic [ADDR_W-1:0] ADR_KEY      = 8'h48;

  localparam int POST_BIT = 4;

  localparam logic [DATA_W-1:0] KEY_STOP_A  = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_STOP_B  = 32'h0000_5555;
  localparam logic [DATA_W-1:0] KEY_START_A = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_START_B = 32'h0000_4444;

  typedef enum logic [1:0] {
    SEQ_IDLE       = 2'd0,
    SEQ_STOP_HALF  = 2'd1,
    SEQ_START_HALF = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntEnable;
    logic doKick;
    logic loadWr;
    logic clear;
  } dpStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_INIT = 'hFFFF0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] loadVal,
  output logic             resetReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadQ;
  logic             reqQ;
  logic             stepNow;
  logic             wrapNow;

  assign stepNow = tick && stb.cntEnable;
  assign wrapNow = stepNow && (cntQ == CNT_MAX);

  // reload register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadQ <= LOAD_INIT;
    end else if (stb.clear) begin
      loadQ <= LOAD_INIT;
    end else if (stb.loadWr) begin
      loadQ <= wrData;
    end
  end

  // up-counter with overflow reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= LOAD_INIT;
      reqQ <= 1'b0;
    end else if (stb.clear) begin
      cntQ <= LOAD_INIT;
      reqQ <= 1'b0;
    end else begin
      reqQ <= wrapNow;
      if (wrapNow || stb.doKick) begin
        cntQ <= loadQ;
      end else if (stepNow) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign cntVal   = cntQ;
  assign loadVal  = loadQ;
  assign resetReq = reqQ;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int POST_TICKS  = 4,
  parameter int SRST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [DATA_W-1:0] busRdata,
  output dpStrobe_t         stb,
  output logic              pendFlag,
  output logic              srstBusy,
  output logic              cntEnable
);
  localparam int PEND_W = $clog2(POST_TICKS + 1);
  localparam int SRST_W = $clog2(SRST_CYCLES + 1);

  logic              busyQ;
  logic              doneQ;
  logic [SRST_W-1:0] srstCntQ;
  logic              wrOk;
  logic              sysCfgWr;
  logic              keyWr;

  logic              pendQ;
  logic [PEND_W-1:0] pendCntQ;
  logic [DATA_W-1:0] postedKeyQ;
  seqState_t         seqQ;
  seqState_t         seqNext;
  logic              enQ;
  logic              enNext;

  assign wrOk     = busWe && !busyQ;
  assign sysCfgWr = wrOk && (busAddr == ADR_SYSCFG);
  assign keyWr    = wrOk && (busAddr == ADR_KEY);

  // soft-reset sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b1;
      srstCntQ <= '0;
    end else if (busyQ) begin
      if (srstCntQ == SRST_W'(1)) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
      srstCntQ <= srstCntQ - 1'b1;
    end else if (sysCfgWr && busWdata[0]) begin
      busyQ    <= 1'b1;
      doneQ    <= 1'b0;
      srstCntQ <= SRST_W'(SRST_CYCLES);
    end
  end

  // key sequence decode on the posted word
  always_comb begin
    seqNext = SEQ_IDLE;
    enNext  = enQ;
    unique case (seqQ)
      SEQ_STOP_HALF: begin
        if (postedKeyQ == KEY_STOP_B) enNext = 1'b0;
      end
      SEQ_START_HALF: begin
        if (postedKeyQ == KEY_START_B) enNext = 1'b1;
      end
      default: begin
        if (postedKeyQ == KEY_STOP_A)       seqNext = SEQ_STOP_HALF;
        else if (postedKeyQ == KEY_START_A) seqNext = SEQ_START_HALF;
      end
    endcase
  end

  // write posting and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ      <= 1'b0;
      pendCntQ   <= '0;
      postedKeyQ <= '0;
      seqQ       <= SEQ_IDLE;
      enQ        <= 1'b1;
    end else if (busyQ) begin
      pendQ      <= 1'b0;
      pendCntQ   <= '0;
      postedKeyQ <= '0;
      seqQ       <= SEQ_IDLE;
      enQ        <= 1'b1;
    end else if (keyWr && !pendQ) begin
      pendQ      <= 1'b1;
      pendCntQ   <= PEND_W'(POST_TICKS);
      postedKeyQ <= busWdata;
    end else if (pendQ && tick) begin
      if (pendCntQ == PEND_W'(1)) begin
        pendQ <= 1'b0;
        seqQ  <= seqNext;
        enQ   <= enNext;
      end
      pendCntQ <= pendCntQ - 1'b1;
    end
  end

  // strobes to the datapath
  always_comb begin
    stb.cntEnable = enQ;
    stb.doKick    = wrOk && (busAddr == ADR_KICK);
    stb.loadWr    = wrOk && (busAddr == ADR_LOAD);
    stb.clear     = busyQ;
  end

  // register read mux
  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADR_SYSCFG:   busRdata[0] = busyQ;
      ADR_SYSSTAT:  busRdata[0] = doneQ;
      ADR_COUNT:    busRdata = DATA_W'(cntVal);
      ADR_LOAD:     busRdata = DATA_W'(loadVal);
      ADR_POSTSTAT: busRdata[POST_BIT] = pendQ;
      default:      busRdata = '0;
    endcase
  end

  assign pendFlag  = pendQ;
  assign srstBusy  = busyQ;
  assign cntEnable = enQ;
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_INIT = 'hFFFF0000,
  parameter int POST_TICKS  = 4,
  parameter int SRST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic        busWe,
  output logic [31:0] busRdata,
  output logic        resetReq
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] loadVal;
  logic             pendFlag;
  logic             srstBusy;
  logic             cntEnable;

  wdog_ctrl #(
    .CNT_W(CNT_W), .POST_TICKS(POST_TICKS), .SRST_CYCLES(SRST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .cntVal(cntVal), .loadVal(loadVal), .busRdata(busRdata),
    .stb(stb), .pendFlag(pendFlag), .srstBusy(srstBusy),
    .cntEnable(cntEnable)
  );

  wdog_datapath #(
    .CNT_W(CNT_W), .LOAD_INIT(LOAD_INIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stb(stb),
    .wrData(busWdata[CNT_W-1:0]),
    .cntVal(cntVal), .loadVal(loadVal), .resetReq(resetReq)
  );
endmodule

// File: rtl/wdog_keyseq_chk.sv
module wdog_keyseq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             busWe,
  input logic             resetReq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] loadVal,
  input logic             pendFlag,
  input logic             srstBusy,
  input logic             cntEnable
);
  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !busWe && !srstBusy) |=> $stable(cntVal));

  // R3
  req_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |-> (cntVal == $past(loadVal)));

  // R3
  req_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |-> $past(tick));

  // R5
  stop_on_applied_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cntEnable) |-> ($past(tick) && $past(pendFlag)));

  // R8
  pend_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendFlag) |-> $past(busWe));

  // R9
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srstBusy && $past(srstBusy)) |-> (!resetReq && !pendFlag && cntEnable));
endmodule

bind wdog_keyseq wdog_keyseq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busWe(busWe),
  .resetReq(resetReq), .cntVal(cntVal), .loadVal(loadVal),
  .pendFlag(pendFlag), .srstBusy(srstBusy), .cntEnable(cntEnable)
);

// File: tb/sim_wdog_keyseq.sv
module sim_wdog_keyseq;
  localparam int CNT_W = 10;
  localparam logic [CNT_W-1:0] LINIT = 10'h3C0;
  localparam int PT = 4;
  localparam int SR = 6;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWe = 1'b0;
  logic [31:0] busRdata;
  logic resetReq;

  int nVec = 0;
  int nErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wdog_keyseq #(.CNT_W(CNT_W), .LOAD_INIT(LINIT), .POST_TICKS(PT),
                .SRST_CYCLES(SR)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .resetReq(resetReq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expCount(input string req, input int v);
    logic [31:0] d;
    rd(8'h28, d);
    chk(req, d, 32'(v));
  endtask

  task automatic expReg(input string req, input logic [7:0] a, input logic [31:0] v);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, v);
  endtask

  task automatic key(input logic [31:0] k);
    wr(8'h48, k);
    ticks(PT);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  initial begin
    int base;
    int n;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expCount("R1", int'(LINIT));
    expReg("R1", 8'h2C, 32'(LINIT));
    expReg("R1", 8'h34, 32'h0);
    expReg("R1", 8'h14, 32'h1);
    expReg("R1", 8'h10, 32'h0);
    chk("R1", 32'(resetReq), 32'h0);

    // R2 count on tick, hold without
    ticks(5);
    expCount("R2", int'(LINIT) + 5);
    idle(5);
    expCount("R2", int'(LINIT) + 5);

    // R4 reload register and kick
    wr(8'h2C, 32'h155);
    expCount("R4", int'(LINIT) + 5);
    expReg("R4", 8'h2C, 32'h155);
    wr(8'h30, 32'h0);
    expCount("R4", 32'h155);

    // R3 overflow sweep over reload values
    for (int i = 0; i < 23; i++) begin
      int lv;
      if (i == 21) lv = 0;
      else if (i == 22) lv = 512;
      else lv = MAXV - i;
      wr(8'h2C, 32'(lv));
      wr(8'h30, 32'h0);
      ticks(MAXV - lv);
      expCount("R3", MAXV);
      chk("R3", 32'(resetReq), 32'h0);
      ticks(1);
      chk("R3", 32'(resetReq), 32'h1);
      expCount("R3", lv);
      idle(1);
      chk("R3", 32'(resetReq), 32'h0);
    end

    // R8 posting delay, R5 stop
    wr(8'h2C, 32'h100);
    wr(8'h30, 32'h0);
    wr(8'h48, 32'h0000AAAA);
    expReg("R8", 8'h34, 32'h10);
    ticks(PT - 1);
    expReg("R8", 8'h34, 32'h10);
    ticks(1);
    expReg("R8", 8'h34, 32'h0);
    expCount("R8", 32'h100 + PT);
    key(32'h00005555);
    expCount("R5", 32'h100 + 2 * PT);
    ticks(10);
    expCount("R5", 32'h100 + 2 * PT);

    // R7 restart
    key(32'h0000BBBB);
    key(32'h00004444);
    expCount("R7", 32'h100 + 2 * PT);
    ticks(3);
    expCount("R7", 32'h100 + 2 * PT + 3);

    // R6 wrong orders
    base = 32'h100 + 2 * PT + 3;
    key(32'h00005555);
    key(32'h0000AAAA);
    key(32'h00001234);
    key(32'h00005555);
    ticks(5);
    expCount("R6", base + 4 * PT + 5);
    base = base + 4 * PT + 5;
    key(32'h0000AAAA);
    key(32'h0000AAAA);
    key(32'h00005555);
    ticks(2);
    expCount("R6", base + 3 * PT + 2);

    // R8 write during pending is dropped and does not restart delay
    key(32'h0000AAAA);
    base = base + 3 * PT + 2 + PT;
    wr(8'h48, 32'h00005555);
    ticks(2);
    wr(8'h48, 32'h00001111);
    ticks(PT - 2);
    expReg("R8", 8'h34, 32'h0);
    expCount("R8", base + PT);
    ticks(4);
    expCount("R8", base + PT);

    // R9 soft reset while stopped
    wr(8'h10, 32'h0);
    expReg("R9", 8'h14, 32'h1);
    wr(8'h2C, 32'h2A);
    wr(8'h10, 32'h1);
    expReg("R9", 8'h10, 32'h1);
    expReg("R9", 8'h14, 32'h0);
    wr(8'h2C, 32'h2);
    n = 1;
    rd(8'h14, d);
    while (d[0] == 1'b0 && n < 50) begin
      @(negedge clk);
      n++;
      rd(8'h14, d);
    end
    chk("R9", 32'(n), 32'(SR));
    expReg("R9", 8'h10, 32'h0);
    expReg("R9", 8'h2C, 32'(LINIT));
    expCount("R9", int'(LINIT));
    expReg("R9", 8'h34, 32'h0);
    ticks(2);
    expCount("R9", int'(LINIT) + 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule